// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into a queue of received characters. A frame starts with a low start bit. Then come 7 or 8 data bits, least significant bit first, then an optional parity bit, then one or two high stop bits. The receiver times each bit from an oversampling tick that the surrounding logic supplies. It samples each bit at its centre and drops a start bit that does not last until its centre.

Each finished character goes into a 16-entry queue that is 10 bits wide. The character sits in the low byte. Two flags sit above it and belong to that character only: one for a parity mismatch and one for a bad stop bit. A consumer reads the queue through a show-ahead port. The fill level is reported in a packed index word. Four single-cycle status pulses report:
- the queue reaching its almost-full level,
- the queue becoming full,
- a character lost because the queue was full,
- a quiet line while data is still waiting.

A loopback select feeds the receiver from an internal transmit-side signal instead of the pin. A synchronous clear empties the queue.

Top module: `serial_rx_tagq`

## Requirements
- R1: With 8 data bits, no parity and one stop bit, a frame is stored as one entry. The first data bit on the line lands in entry bit 0, and the byte fills entry bits 7:0. Entries leave the queue in arrival order, and `rd_entry` shows the oldest entry while the queue is not empty.
- R2: When `cfg_eight_bits` is 0, only 7 data bits are received, and entry bit 7 is stored as 0.
- R3: When `cfg_par_en` is 1, the bit after the data is taken as parity. Entry bit 8 is set when the data bits and the parity bit together have an even count of ones while `cfg_par_odd` is 1, or an odd count while `cfg_par_odd` is 0. Otherwise bit 8 is 0. Bit 8 is always 0 with parity disabled.
- R4: A first stop bit sampled low sets entry bit 9, and the character is still stored.
- R5: When `cfg_two_stop` is 1, the receiver waits for a second stop bit before storing. Only the first stop bit decides the framing flag.
- R6: A low level on the line that ends before the middle of the start bit stores nothing.
- R7: While `cfg_rx_en` is 0, no character is stored.
- R8: While `cfg_loopback` is 1, frames are taken from `lb_line` and `rx_line` is ignored.
- R9: `idx_word` carries the number of stored entries (0..16) in bits 12:8, and all its other bits are 0. A read while the queue is empty has no effect.
- R10: `irq_almost_full` pulses for one cycle when the fill level rises to AF_LEVEL (12 by default). `irq_full` pulses for one cycle when the level rises to 16.
- R11: A character that completes while 16 entries are held is discarded and `irq_overrun` pulses. The stored entries and the fill level do not change.
- R12: `irq_timeout` pulses once when the queue is not empty and the receiver has been idle for TOUT_CHARS × FRAME_BITS × OVS ticks (4 × 10 × OVS by default). It does not pulse while the queue is empty.
- R13: A one-cycle `fifo_clr` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| rx_line | input | 1 | Serial input pin, idle high |
| lb_line | input | 1 | Internal transmit-side signal used in loopback |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_loopback | input | 1 | Take frames from lb_line |
| fifo_clr | input | 1 | Synchronous queue clear |
| rd_en | input | 1 | Pop the oldest entry |
| rd_entry | output | 10 | Oldest entry: {frame err, parity err, data[7:0]} |
| idx_word | output | 16 | Fill level in bits 12:8 |
| irq_almost_full | output | 1 | Almost-full pulse |
| irq_full | output | 1 | Full pulse |
| irq_overrun | output | 1 | Character-lost pulse |
| irq_timeout | output | 1 | Receive-timeout pulse |

## Verification
The bench builds the block with OVS = 4 and holds the tick high. A bit then lasts four clocks, so a frame takes about forty cycles and the timeout window is 160 cycles. This keeps filling all 16 entries, forcing an overrun and waiting through whole timeout windows short. With OVS = 4 the centre check falls two ticks after the falling edge, so a one-cycle glitch and a low second stop bit both exercise the rejection of a start bit that is gone by its centre. Depth and almost-full level keep their defaults, so both level pulses and the overrun are checked at the sizes a user gets.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned ENTRY_W = 10;
   localparam int unsigned DATA_W  = 8;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
   } rx_state_e;
endpackage

// File: rtl/rxq_deframer.sv
module rxq_deframer
   import rxq_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               rx_en,
   input  logic               eight,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic               two_stop,
   input  logic               line_in,
   output logic               push,
   output logic [ENTRY_W-1:0] entry,
   output logic               busy
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned HALF = OVS / 2;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      initial $fatal(1, "OVS must be even and at least 4");
   end

   logic s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign s = line_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], line_in} & '1;
      end
      assign s = chain[SYNC_STAGES-1];
   end

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [2:0]        bidx;
   logic [DATA_W-1:0] shreg;
   logic              perr_q, ferr_q;
   logic [DATA_W-1:0] aligned;
   logic [2:0]        last_idx;
   logic              bit_pt;

   assign aligned  = eight ? shreg : {1'b0, shreg[DATA_W-1:1]};
   assign last_idx = eight ? 3'd7 : 3'd6;
   assign bit_pt   = (cnt == CW'(OVS - 1));
   assign busy     = (state != RX_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
         push   <= 1'b0;
         entry  <= '0;
      end else begin
         push <= 1'b0;
         if (!rx_en) begin
            state <= RX_IDLE;
         end else if (tick) begin
            cnt <= cnt + 1'b1;
            unique case (state)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!s) state <= RX_START;
               end
               RX_START: if (cnt == CW'(HALF - 1)) begin
                  cnt    <= '0;
                  bidx   <= '0;
                  perr_q <= 1'b0;
                  state  <= s ? RX_IDLE : RX_DATA;
               end
               RX_DATA: if (bit_pt) begin
                  cnt   <= '0;
                  shreg <= {s, shreg[DATA_W-1:1]};
                  bidx  <= bidx + 1'b1;
                  if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP1;
               end
               RX_PAR: if (bit_pt) begin
                  cnt    <= '0;
                  perr_q <= (^aligned) ^ s ^ par_odd;
                  state  <= RX_STOP1;
               end
               RX_STOP1: if (bit_pt) begin
                  cnt    <= '0;
                  ferr_q <= !s;
                  if (two_stop) begin
                     state <= RX_STOP2;
                  end else begin
                     push  <= 1'b1;
                     entry <= {!s, perr_q, aligned};
                     state <= RX_IDLE;
                  end
               end
               RX_STOP2: if (bit_pt) begin
                  cnt   <= '0;
                  push  <= 1'b1;
                  entry <= {ferr_q, perr_q, aligned};
                  state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R7: a stored character implies the receiver was enabled in the cycle before
   p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(rx_en));
   // R6: a frame body is only entered after the start bit was confirmed low at its centre
   p_start_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_DATA && $past(state) == RX_START) |-> $past(!s));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned WIDTH    = 10,
   parameter int unsigned AF_LEVEL = 12,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count,
   output logic             af_pulse,
   output logic             full_pulse,
   output logic             ovr_pulse
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      initial $fatal(1, "DEPTH must be a power of two");
   end
   if (AF_LEVEL == 0 || AF_LEVEL >= DEPTH) begin : g_bad_af
      initial $fatal(1, "AF_LEVEL must lie between 1 and DEPTH-1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             full, empty, push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0; rptr <= '0; count <= '0;
         af_pulse <= 1'b0; full_pulse <= 1'b0; ovr_pulse <= 1'b0;
      end else begin
         af_pulse   <= !clr && push_ok && !pop_ok && count == CNT_W'(AF_LEVEL - 1);
         full_pulse <= !clr && push_ok && !pop_ok && count == CNT_W'(DEPTH - 1);
         ovr_pulse  <= !clr && push && full;
         if (clr) begin
            wptr <= '0; rptr <= '0; count <= '0;
         end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
         end
      end
   end

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   p_overrun_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_pulse |-> ($past(count) == CNT_W'(DEPTH) && count == CNT_W'(DEPTH) - CNT_W'($past(pop_ok))));
   p_full_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full_pulse |-> count == CNT_W'(DEPTH));
   p_af_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      af_pulse |-> count == CNT_W'(AF_LEVEL));
   p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/rxq_idle_watch.sv
module rxq_idle_watch #(
   parameter int unsigned LIMIT = 640,
   localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic busy,
   input  logic nonempty,
   output logic pulse
);
   logic [TW-1:0] cnt;
   logic          fired;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0; fired <= 1'b0; pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (busy || !nonempty) begin
            cnt   <= '0;
            fired <= 1'b0;
         end else if (tick && !fired) begin
            if (cnt == TW'(LIMIT - 1)) begin
               pulse <= 1'b1;
               fired <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_timeout_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(nonempty && !busy));
   p_timeout_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
   import rxq_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned AF_LEVEL    = 12,
   parameter int unsigned TOUT_CHARS  = 4,
   parameter int unsigned FRAME_BITS  = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               os_tick,
   input  logic               rx_line,
   input  logic               lb_line,
   input  logic               cfg_rx_en,
   input  logic               cfg_eight_bits,
   input  logic               cfg_par_en,
   input  logic               cfg_par_odd,
   input  logic               cfg_two_stop,
   input  logic               cfg_loopback,
   input  logic               fifo_clr,
   input  logic               rd_en,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [15:0]        idx_word,
   output logic               irq_almost_full,
   output logic               irq_full,
   output logic               irq_overrun,
   output logic               irq_timeout
);
   localparam int unsigned CNT_W      = $clog2(DEPTH + 1);
   localparam int unsigned TOUT_TICKS = TOUT_CHARS * FRAME_BITS * OVS;

   if (CNT_W > 8) begin : g_bad_idx
      initial $fatal(1, "fill level does not fit the index field");
   end

   logic               line_sel, push, busy;
   logic [ENTRY_W-1:0] entry;
   logic [CNT_W-1:0]   count;

   assign line_sel = cfg_loopback ? lb_line : rx_line;

   rxq_deframer #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_deframer (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_en(cfg_rx_en),
      .eight(cfg_eight_bits), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
      .two_stop(cfg_two_stop), .line_in(line_sel),
      .push(push), .entry(entry), .busy(busy)
   );

   rxq_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .AF_LEVEL(AF_LEVEL)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .wdata(entry),
      .pop(rd_en), .rdata(rd_entry), .count(count),
      .af_pulse(irq_almost_full), .full_pulse(irq_full), .ovr_pulse(irq_overrun)
   );

   rxq_idle_watch #(.LIMIT(TOUT_TICKS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .busy(busy),
      .nonempty(count != '0), .pulse(irq_timeout)
   );

   always_comb begin
      idx_word = '0;
      idx_word[8 +: CNT_W] = count;
   end

   p_idx_pack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_word[7:0] == 8'h00) && (idx_word[15:8+CNT_W] == '0));
endmodule

// File: tb/serial_rx_tagq_bench.sv
`timescale 1ns/1ps
module serial_rx_tagq_bench;
   localparam int OVS = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_line = 1'b1, lb_line = 1'b1;
   logic cfg_rx_en = 1'b1, cfg_eight_bits = 1'b1, cfg_par_en = 1'b0;
   logic cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_loopback = 1'b0;
   logic fifo_clr = 1'b0, rd_en = 1'b0;
   logic [9:0]  rd_entry;
   logic [15:0] idx_word;
   logic irq_almost_full, irq_full, irq_overrun, irq_timeout;

   int checks = 0, failures = 0;
   int n_af = 0, n_full = 0, n_ovr = 0, n_to = 0;
   bit use_lb = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   serial_rx_tagq #(.OVS(OVS)) u_serial_rx_tagq (
      .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rx_line(rx_line), .lb_line(lb_line),
      .cfg_rx_en(cfg_rx_en), .cfg_eight_bits(cfg_eight_bits), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_loopback(cfg_loopback),
      .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_entry(rd_entry), .idx_word(idx_word),
      .irq_almost_full(irq_almost_full), .irq_full(irq_full),
      .irq_overrun(irq_overrun), .irq_timeout(irq_timeout)
   );

   always @(negedge clk) begin
      if (irq_almost_full) n_af++;
      if (irq_full)        n_full++;
      if (irq_overrun)     n_ovr++;
      if (irq_timeout)     n_to++;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      if (use_lb) lb_line = v; else rx_line = v;
      repeat (OVS) @(negedge clk);
   endtask

   // sends one frame using the current line settings; optional error injection
   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit bad_stop2);
      int nb = cfg_eight_bits ? 8 : 7;
      logic p = 1'b0;
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) begin
         drive_bit(d[i]);
         p ^= d[i];
      end
      if (cfg_par_en) drive_bit(p ^ cfg_par_odd ^ bad_par);
      drive_bit(!bad_stop);
      if (cfg_two_stop) drive_bit(!bad_stop2);
      repeat (3) drive_bit(1'b1);
   endtask

   task automatic pop_expect(input string req, input logic [9:0] exp);
      check(req, {6'd0, rd_entry}, {6'd0, exp});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_queue();
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R9 reset idx", idx_word, 16'h0000);
      check("R10 reset pulses", {12'd0, irq_almost_full, irq_full, irq_overrun, irq_timeout}, 16'h0);
   endtask

   task automatic t_basic();   // R1 R9
      send(8'hA5, 0, 0, 0);
      send(8'h3C, 0, 0, 0);
      check("R9 count two", idx_word, 16'h0200);
      pop_expect("R1 first", 10'h0A5);
      pop_expect("R1 second", 10'h03C);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
      check("R9 pop empty", idx_word, 16'h0000);
   endtask

   task automatic t_seven();   // R2
      cfg_eight_bits = 1'b0;
      send(8'hD5, 0, 0, 0);
      pop_expect("R2 seven bit", 10'h055);
      cfg_eight_bits = 1'b1;
   endtask

   task automatic t_parity();  // R3
      cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      send(8'h71, 0, 0, 0);
      send(8'h71, 1, 0, 0);
      cfg_par_odd = 1'b1;
      send(8'h0F, 0, 0, 0);
      send(8'h0F, 1, 0, 0);
      pop_expect("R3 even ok", 10'h071);
      pop_expect("R3 even bad", 10'h171);
      pop_expect("R3 odd ok", 10'h00F);
      pop_expect("R3 odd bad", 10'h10F);
      cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
   endtask

   task automatic t_frame();   // R4
      send(8'h5A, 0, 1, 0);
      check("R4 stored", idx_word, 16'h0100);
      pop_expect("R4 frame flag", 10'h25A);
   endtask

   task automatic t_two_stop(); // R5
      cfg_two_stop = 1'b1;
      send(8'h81, 0, 0, 1);
      send(8'h42, 0, 1, 0);
      send(8'h99, 0, 0, 0);
      check("R5 count", idx_word, 16'h0300);
      pop_expect("R5 second stop ignored", 10'h081);
      pop_expect("R5 first stop flag", 10'h242);
      pop_expect("R5 clean", 10'h099);
      cfg_two_stop = 1'b0;
   endtask

   task automatic t_glitch();  // R6
      rx_line = 1'b0;
      @(negedge clk);
      rx_line = 1'b1;
      repeat (60) @(negedge clk);
      check("R6 glitch", idx_word, 16'h0000);
   endtask

   task automatic t_disabled(); // R7
      cfg_rx_en = 1'b0;
      send(8'h66, 0, 0, 0);
      check("R7 disabled", idx_word, 16'h0000);
      cfg_rx_en = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_loop();    // R8
      cfg_loopback = 1'b1;
      rx_line = 1'b0;
      use_lb = 1'b1;
      send(8'hC3, 0, 0, 0);
      check("R8 one entry", idx_word, 16'h0100);
      pop_expect("R8 loop data", 10'h0C3);
      use_lb = 1'b0;
      rx_line = 1'b1;
      cfg_loopback = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_fill();    // R10 R11 R13
      clear_queue();
      n_af = 0; n_full = 0; n_ovr = 0;
      for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 0, 0, 0);
      check("R10 almost full pulse", 16'(n_af), 16'd1);
      check("R10 full pulse", 16'(n_full), 16'd1);
      check("R10 full level", idx_word, 16'h1000);
      send(8'hEE, 0, 0, 0);
      check("R11 overrun pulse", 16'(n_ovr), 16'd1);
      check("R11 level kept", idx_word, 16'h1000);
      check("R11 head kept", {6'd0, rd_entry}, 16'h0010);
      clear_queue();
      check("R13 clear", idx_word, 16'h0000);
   endtask

   task automatic t_timeout(); // R12
      clear_queue();
      n_to = 0;
      send(8'h24, 0, 0, 0);
      repeat (100) @(negedge clk);
      check("R12 not yet", 16'(n_to), 16'd0);
      repeat (100) @(negedge clk);
      check("R12 fired", 16'(n_to), 16'd1);
      repeat (300) @(negedge clk);
      check("R12 once", 16'(n_to), 16'd1);
      clear_queue();
      n_to = 0;
      repeat (400) @(negedge clk);
      check("R12 empty quiet", 16'(n_to), 16'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic();
      t_seven();
      t_parity();
      t_frame();
      t_two_stop();
      t_glitch();
      t_disabled();
      t_loop();
      t_fill();
      t_timeout();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule